// File: doc/BRIEF.md
# System Reset Control Port

This block is a one-byte register on the I/O space that lets software ask for a full system reset. A write to its port address either starts a reset request at once or records the reset type that software wants for a later request. The block sends a one-cycle request pulse to an external reset controller. The reset sequence that the system then runs is handled outside the block.

The I/O side has a valid strobe, a write enable, a 16-bit address and 8-bit data. The block decodes only its own port address. Read data is combinational and valid in the same cycle as the read strobe. Write effects take hold at the next clock edge.

Top module: `rst_ctl_port`

## Requirements
- R1: Only the port address `PORT_ADDR` (default 16'hCF9) is decoded. A write to any other address leaves the stored value unchanged and raises no request.
- R2: A write to the port with bit 2 (trigger) set raises a request and leaves the stored value unchanged.
- R3: A write to the port with bit 2 clear stores bit 1 (reset type) of the write data. All other stored bits become zero.
- R4: A read of the port returns the stored value in the same cycle. Only bit 1 can ever read back as one.
- R5: While `rst_n` is low at a clock edge, the stored value clears to zero and `sys_rst_req` goes low.
- R6: `sys_rst_req` is high for exactly the one cycle after the clock edge that captures a trigger write, and low at all other times.
- R7: `io_rvalid` is high only for a read (`io_valid`=1, `io_write`=0) at the port address. Reads of any other address return zero with `io_rvalid` low.
- R8: Trigger writes in consecutive cycles each produce their own request cycle, so `sys_rst_req` stays high for one cycle per write.
- R9: Reads do not change the stored value and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_valid | input | 1 | I/O access strobe |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero unless `io_rvalid` is high |
| io_rvalid | output | 1 | Read data valid for the decoded port |
| sys_rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The only internal state is the stored reset-type bit and the request flop. A wrong stored bit shows on the very next read of the port as a mismatch in bit 1, or as a stray one in another bit position. A wrong request flop shows one cycle after the write, as a missing pulse, a stretched pulse or a spurious pulse. The bench reads the port back after each write, so a corrupted store is caught within one access.

// File: rtl/rcr_pkg.sv
// Package: shared widths and bit positions for the reset control port.
// Assumes an 8-bit data path and 16-bit I/O addresses by default.
package rcr_pkg;
    localparam int unsigned IO_ADDR_W = 16;
    localparam int unsigned IO_DATA_W = 8;
    localparam logic [IO_ADDR_W-1:0] DEF_PORT_ADDR = 16'hCF9;
    localparam int unsigned DEF_TRIG_BIT = 2;
    localparam int unsigned DEF_TYPE_BIT = 1;

    // Kind of access the decoder found for the current cycle
    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10
    } acc_kind_e;
endpackage

// File: rtl/rcr_decode.sv
// Module: address decoder for the reset control port.
// Sorts each cycle into a port read, a port write or no access.
// Assumes io_valid qualifies io_write and io_addr.
module rcr_decode #(
    parameter int unsigned ADDR_W = rcr_pkg::IO_ADDR_W,
    parameter logic [ADDR_W-1:0] PORT_ADDR = rcr_pkg::DEF_PORT_ADDR
) (
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    output rcr_pkg::acc_kind_e acc
);
    // Purpose: classify the access against the single decoded address
    always_comb begin
        acc = rcr_pkg::ACC_NONE;
        if (io_valid && (io_addr == PORT_ADDR)) begin
            acc = io_write ? rcr_pkg::ACC_WRITE : rcr_pkg::ACC_READ;
        end
    end
endmodule

// File: rtl/rcr_store.sv
// Module: storage and request pulse for the reset control port.
// A port write with the trigger bit set raises a one-cycle request and keeps
// the stored byte. Any other port write keeps only the type bit.
// Assumes a synchronous active-low reset.
module rcr_store #(
    parameter int unsigned DATA_W   = rcr_pkg::IO_DATA_W,
    parameter int unsigned TRIG_BIT = rcr_pkg::DEF_TRIG_BIT,
    parameter int unsigned TYPE_BIT = rcr_pkg::DEF_TYPE_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rcr_pkg::acc_kind_e acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stored_q,
    output logic              req_q
);
    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << TYPE_BIT;

    logic is_wr;
    logic is_trig;

    // Purpose: split port writes into trigger writes and type writes
    always_comb begin
        is_wr   = (acc == rcr_pkg::ACC_WRITE);
        is_trig = is_wr && wdata[TRIG_BIT];
    end

    // Purpose: hold the filtered type byte; trigger writes leave it alone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_q <= '0;
        end else if (is_wr && !is_trig) begin
            stored_q <= wdata & KEEP_MASK;
        end
    end

    // Purpose: register one request cycle for each trigger write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= is_trig;
        end
    end
endmodule

// File: rtl/rcr_rdmux.sv
// Module: read path for the reset control port.
// Returns the stored byte for a port read and zero otherwise.
module rcr_rdmux #(
    parameter int unsigned DATA_W = rcr_pkg::IO_DATA_W
) (
    input  rcr_pkg::acc_kind_e acc,
    input  logic [DATA_W-1:0] stored_q,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    // Purpose: gate the stored byte onto the read bus for port reads only
    always_comb begin
        rvalid = (acc == rcr_pkg::ACC_READ);
        rdata  = rvalid ? stored_q : '0;
    end
endmodule

// File: rtl/rst_ctl_port.sv
// Module: top of the system reset control port.
// Contains the decoder, the storage and request logic, and the read mux.
// Assumes one I/O access per cycle and a synchronous active-low reset.
module rst_ctl_port #(
    parameter int unsigned ADDR_W   = rcr_pkg::IO_ADDR_W,
    parameter int unsigned DATA_W   = rcr_pkg::IO_DATA_W,
    parameter logic [ADDR_W-1:0] PORT_ADDR = rcr_pkg::DEF_PORT_ADDR,
    parameter int unsigned TRIG_BIT = rcr_pkg::DEF_TRIG_BIT,
    parameter int unsigned TYPE_BIT = rcr_pkg::DEF_TYPE_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rvalid,
    output logic              sys_rst_req
);
    rcr_pkg::acc_kind_e acc;
    logic [DATA_W-1:0]  stored_q;

    rcr_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
        .io_valid (io_valid),
        .io_write (io_write),
        .io_addr  (io_addr),
        .acc      (acc)
    );

    rcr_store #(.DATA_W(DATA_W), .TRIG_BIT(TRIG_BIT), .TYPE_BIT(TYPE_BIT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .wdata    (io_wdata),
        .stored_q (stored_q),
        .req_q    (sys_rst_req)
    );

    rcr_rdmux #(.DATA_W(DATA_W)) u_rd (
        .acc      (acc),
        .stored_q (stored_q),
        .rdata    (io_rdata),
        .rvalid   (io_rvalid)
    );
endmodule

// File: rtl/rcr_checker.sv
// Module: property checker for the reset control port, bound to the top.
// Watches the ports and the stored byte.
module rcr_checker #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
    parameter int unsigned TRIG_BIT = 2,
    parameter int unsigned TYPE_BIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_valid,
    input logic              io_write,
    input logic [ADDR_W-1:0] io_addr,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic              io_rvalid,
    input logic              sys_rst_req,
    input logic [DATA_W-1:0] stored_q
);
    localparam logic [DATA_W-1:0] ONLY_TYPE = DATA_W'(1) << TYPE_BIT;

    logic port_wr;
    logic trig_wr;
    assign port_wr = io_valid && io_write && (io_addr == PORT_ADDR);
    assign trig_wr = port_wr && io_wdata[TRIG_BIT];

    // R2, R8: every trigger write is followed by a request cycle
    p_trig_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> sys_rst_req);
    // R2: a trigger write keeps the stored byte
    p_trig_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> $stable(stored_q));
    // R3: a type write keeps only the type bit
    p_type_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !io_wdata[TRIG_BIT]) |=> (stored_q == ($past(io_wdata) & ONLY_TYPE)));
    // R4: a port read only ever returns the type bit
    p_rdata_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |-> ((io_rdata & ~ONLY_TYPE) == '0));
    // R6: no request unless a trigger write came just before
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_wr |=> !sys_rst_req);
    // R7: read valid only for a port read
    p_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |-> (io_valid && !io_write && io_addr == PORT_ADDR));
    // R1, R9: without a port write the stored byte holds
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(stored_q));
endmodule

bind rst_ctl_port rcr_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR),
    .TRIG_BIT(TRIG_BIT), .TYPE_BIT(TYPE_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .sys_rst_req(sys_rst_req), .stored_q(stored_q)
);

// File: tb/sim_rst_ctl_port.sv
// Bench: directed corners plus seeded random traffic, checked against a model.
module sim_rst_ctl_port;
    localparam logic [15:0] PORT = 16'hCF9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_valid = 1'b0;
    logic       io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       io_rvalid;
    logic       sys_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model = 8'h00;

    always #4 clk = ~clk;

    rst_ctl_port u0 (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_rvalid(io_rvalid), .sys_rst_req(sys_rst_req)
    );

    function automatic logic [7:0] next_model(logic [7:0] cur, logic [15:0] a, logic [7:0] d);
        if (a != PORT || d[2]) return cur;
        return d & 8'h02;
    endfunction

    function automatic logic exp_req(logic [15:0] a, logic [7:0] d);
        return (a == PORT) && d[2];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge. Drives a write and returns at the next negedge,
    // after checking the request pulse.
    task automatic wr(logic [15:0] a, logic [7:0] d);
        io_valid = 1'b1; io_write = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        check(exp_req(a, d) ? "R2/R8 req" : "R1/R6 req", sys_rst_req, exp_req(a, d));
        model = next_model(model, a, d);
        io_valid = 1'b0; io_write = 1'b0;
    endtask

    // Called at a negedge. Checks the combinational read in the same cycle,
    // then the absence of a request after the edge.
    task automatic rd(logic [15:0] a);
        io_valid = 1'b1; io_write = 1'b0; io_addr = a; io_wdata = $urandom;
        #1;
        check("R4/R7 rvalid", io_rvalid, a == PORT);
        check("R4/R7 rdata", io_rdata, (a == PORT) ? model : 8'h00);
        @(negedge clk);
        check("R9 no req on read", sys_rst_req, 1'b0);
        io_valid = 1'b0;
    endtask

    task automatic idle_chk;
        @(negedge clk);
        check("R6 single cycle", sys_rst_req, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0CF9));
        repeat (3) @(negedge clk);
        // R5: reset state
        check("R5 req in reset", sys_rst_req, 1'b0);
        rst_n = 1'b1;
        rd(PORT);
        // R3: type bit stored, others dropped
        wr(PORT, 8'hFB); rd(PORT);
        wr(PORT, 8'h02); rd(PORT);
        wr(PORT, 8'hF9); rd(PORT);
        wr(PORT, 8'h02);
        // R2: trigger keeps stored value
        wr(PORT, 8'h04); idle_chk(); rd(PORT);
        wr(PORT, 8'hFF); rd(PORT);
        // R8: back-to-back triggers
        wr(PORT, 8'h04); wr(PORT, 8'h06); wr(PORT, 8'h00); idle_chk(); rd(PORT);
        // R1: neighbour addresses ignored
        wr(PORT + 16'd1, 8'h02); rd(PORT);
        wr(PORT - 16'd1, 8'h04); rd(PORT);
        wr(16'h0CF8, 8'h00); rd(PORT);
        // R7: other address reads return zero
        rd(16'h0CF8); rd(16'h0000);
        wr(PORT, 8'h02);
        // R5: reset mid-run clears the stored value
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        model = 8'h00;
        rd(PORT);
        wr(PORT, 8'h04); rst_n = 1'b0; @(negedge clk);
        check("R5 req cleared by reset", sys_rst_req, 1'b0);
        rst_n = 1'b1;
        // Random traffic
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            a = ($urandom % 4 != 0) ? PORT : 16'($urandom);
            if ($urandom % 2 != 0) wr(a, 8'($urandom));
            else rd(a);
            if ($urandom % 5 == 0) rd(PORT);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule